// File: doc/BRIEF.md
# Sequential Shift-Subtract Integer Divider

This block divides one WIDTH-bit integer by another over several clock cycles. It works one quotient bit per clock. It keeps a divisor register, a partial-remainder register and a register that starts out holding the dividend and ends up holding the quotient. On each step it shifts the remainder and quotient pair left by one bit. It then tries to remove the divisor from the partial remainder. It keeps the trial value if the attempt is legal and records a one in the freed quotient bit. Otherwise it keeps the shifted value and records a zero.

A mode input selects unsigned or two's-complement operation. In two's-complement mode the remainder register is loaded with copies of the dividend's sign bit. Each step subtracts the divisor when the divisor and the partial remainder have the same sign, and adds it when they differ. The step is undone when the sign of the partial remainder flips. When the signs of the two operands differ, the finished quotient is negated.

A caller pulses `start` with the operands. It waits while `busy` is high and collects the quotient and remainder in the cycle `done` is high. The results stay on the outputs until the next accepted start.

Top module: `seq_divider`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `busy`, `done` and `div_zero` are 0, and `quotient` and `remainder` are 0.
- R2: With `is_signed`=0, both operands are unsigned, even with the top bit set. The quotient is the floor of dividend/divisor and the remainder is dividend minus quotient times divisor, so the remainder is below the divisor. Example: 147/11 gives 13 remainder 4.
- R3: With `is_signed`=1, both operands are two's-complement. The quotient is rounded toward zero (for example -7/2 gives -3), and it is negated when the operand signs differ.
- R4: With `is_signed`=1, the remainder is zero or has the sign of the dividend. Its magnitude is below that of the divisor, and quotient times divisor plus remainder equals the dividend.
- R5: A start taken in idle with a non-zero divisor raises `busy` for exactly WIDTH cycles, one division step per cycle. `done` is then high in the single cycle that follows.
- R6: `done` is high for one cycle only, and `busy` and `done` are never high together.
- R7: A start with a zero divisor performs no steps. In the next cycle `done` and `div_zero` are 1 and `busy` stays 0. `quotient` is all ones and `remainder` equals the dividend.
- R8: A `start` pulse while `busy` is high is ignored. The result and its timing belong to the earlier operands.
- R9: `quotient`, `remainder` and `div_zero` hold their values from the end of an operation until the next accepted start, and input changes in between do not affect them. An accepted start with a non-zero divisor clears `div_zero`.
- R10: In signed mode the most negative value divided by -1 wraps, so the quotient equals the most negative value and the remainder is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a division with the present operands (taken only when idle) |
| is_signed | input | 1 | 1 selects two's-complement operands, 0 selects unsigned |
| dividend | input | WIDTH | Dividend |
| divisor | input | WIDTH | Divisor |
| busy | output | 1 | Division steps in progress |
| done | output | 1 | One-cycle pulse: results are valid |
| quotient | output | WIDTH | Quotient of the last operation |
| remainder | output | WIDTH | Remainder of the last operation |
| div_zero | output | 1 | Last operation had a zero divisor |

## Verification
The checker watches the handshake on every cycle:
- `done` is a single pulse and never overlaps `busy`.
- Every busy period lasts exactly WIDTH cycles.
- A zero divisor completes at once with the flag set.
- The results do not move during a busy period.
- Against the operands captured at start, the remainder bound holds in both modes.

Exact quotient and remainder values can only be shown by the bench's vectors. These cover rounding toward zero, the wrap of the most negative value divided by -1, and operands whose remainder reaches zero part-way through a negative dividend. The bench also shows that a start during a busy period is ignored and that results are held while idle.

// File: rtl/div_pkg.sv
package div_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } div_state_e;
endpackage

// File: rtl/div_step.sv
// One shift-and-trial step of the divider, purely combinational.
module div_step #(
    parameter int WIDTH = 8,
    parameter int CW    = 4
) (
    input  logic [WIDTH:0]   a_i,      // partial remainder, one guard bit
    input  logic [WIDTH-1:0] q_i,      // unconsumed dividend / quotient bits
    input  logic [WIDTH:0]   m_i,      // divisor, extended per mode
    input  logic             signed_i,
    input  logic [CW-1:0]    left_i,   // steps remaining, this one included
    output logic [WIDTH:0]   a_o,
    output logic [WIDTH-1:0] q_o
);
    localparam int EW = WIDTH + 2;

    logic [WIDTH:0]   a_sh;
    logic [WIDTH-1:0] q_sh;
    logic [EW-1:0]    a_ext;
    logic [EW-1:0]    m_ext;
    logic [EW-1:0]    trial;
    logic [WIDTH:0]   tail;
    logic             use_add;
    logic             rest_zero;
    logic             ok;
    int               shamt;

    always_comb begin
        a_sh    = {a_i[WIDTH-1:0], q_i[WIDTH-1]};
        q_sh    = {q_i[WIDTH-2:0], 1'b0};
        a_ext   = {signed_i & a_sh[WIDTH], a_sh};
        m_ext   = {signed_i & m_i[WIDTH], m_i};
        use_add = signed_i && (a_ext[EW-1] != m_ext[EW-1]);
        trial   = use_add ? (a_ext + m_ext) : (a_ext - m_ext);
        // dividend bits not yet shifted into the remainder
        shamt     = WIDTH + 1 - int'(left_i);
        tail      = {1'b0, q_sh} >> shamt;
        rest_zero = (tail == '0);
        // keep the trial when the sign holds, or when it lands exactly on
        // zero with nothing left below it
        ok  = (trial[EW-1] == a_ext[EW-1]) || ((trial == '0) && rest_zero);
        a_o = ok ? trial[WIDTH:0] : a_sh;
        q_o = {q_sh[WIDTH-1:1], ok};
    end
endmodule

// File: rtl/div_fixup.sv
// Final sign correction of the quotient and narrowing of the remainder.
module div_fixup #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] q_i,
    input  logic [WIDTH:0]   a_i,
    input  logic             neg_i,
    output logic [WIDTH-1:0] quo_o,
    output logic [WIDTH-1:0] rem_o
);
    always_comb begin
        quo_o = neg_i ? (~q_i + 1'b1) : q_i;
        rem_o = a_i[WIDTH-1:0];
    end
endmodule

// File: rtl/seq_divider.sv
module seq_divider #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             is_signed,
    input  logic [WIDTH-1:0] dividend,
    input  logic [WIDTH-1:0] divisor,
    output logic             busy,
    output logic             done,
    output logic [WIDTH-1:0] quotient,
    output logic [WIDTH-1:0] remainder,
    output logic             div_zero
);
    import div_pkg::*;

    localparam int CW = $clog2(WIDTH + 1);
    localparam logic [CW-1:0] STEPS = CW'(WIDTH);

    typedef struct packed {
        div_state_e       state;
        logic [CW-1:0]    cnt;
        logic [WIDTH:0]   a;
        logic [WIDTH-1:0] q;
        logic [WIDTH:0]   m;
        logic             sgn;
        logic             neg;
        logic [WIDTH-1:0] quo;
        logic [WIDTH-1:0] rem;
        logic             dz;
        logic             done;
    } div_regs_t;

    div_regs_t r_q, r_d;

    logic [WIDTH:0]   step_a;
    logic [WIDTH-1:0] step_q;
    logic [WIDTH-1:0] fix_quo;
    logic [WIDTH-1:0] fix_rem;

    div_step #(.WIDTH(WIDTH), .CW(CW)) u_step (
        .a_i      (r_q.a),
        .q_i      (r_q.q),
        .m_i      (r_q.m),
        .signed_i (r_q.sgn),
        .left_i   (r_q.cnt),
        .a_o      (step_a),
        .q_o      (step_q)
    );

    div_fixup #(.WIDTH(WIDTH)) u_fix (
        .q_i   (step_q),
        .a_i   (step_a),
        .neg_i (r_q.neg),
        .quo_o (fix_quo),
        .rem_o (fix_rem)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (start) begin
                    if (divisor == '0) begin
                        r_d.dz   = 1'b1;
                        r_d.done = 1'b1;
                        r_d.quo  = '1;
                        r_d.rem  = dividend;
                    end else begin
                        r_d.state = ST_RUN;
                        r_d.cnt   = STEPS;
                        r_d.dz    = 1'b0;
                        r_d.sgn   = is_signed;
                        r_d.q     = dividend;
                        r_d.a     = {(WIDTH+1){is_signed & dividend[WIDTH-1]}};
                        r_d.m     = {is_signed & divisor[WIDTH-1], divisor};
                        r_d.neg   = is_signed & (dividend[WIDTH-1] ^ divisor[WIDTH-1]);
                    end
                end
            end
            ST_RUN: begin
                r_d.a   = step_a;
                r_d.q   = step_q;
                r_d.cnt = r_q.cnt - 1'b1;
                if (r_q.cnt == CW'(1)) begin
                    r_d.state = ST_IDLE;
                    r_d.done  = 1'b1;
                    r_d.quo   = fix_quo;
                    r_d.rem   = fix_rem;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy      = (r_q.state == ST_RUN);
    assign done      = r_q.done;
    assign quotient  = r_q.quo;
    assign remainder = r_q.rem;
    assign div_zero  = r_q.dz;
endmodule

// File: rtl/divider_chk.sv
module divider_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             is_signed,
    input logic [WIDTH-1:0] dividend,
    input logic [WIDTH-1:0] divisor,
    input logic             busy,
    input logic             done,
    input logic [WIDTH-1:0] quotient,
    input logic [WIDTH-1:0] remainder,
    input logic             div_zero
);
    localparam int LW = $clog2(WIDTH + 2) + 1;

    logic [LW-1:0]    run_len;
    logic             cap_sgn;
    logic [WIDTH-1:0] cap_dvs;
    logic [WIDTH-1:0] abs_rem;
    logic [WIDTH-1:0] abs_dvs;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_len <= '0;
            cap_sgn <= 1'b0;
            cap_dvs <= '0;
        end else begin
            run_len <= busy ? run_len + 1'b1 : '0;
            if (start && !busy && divisor != '0) begin
                cap_sgn <= is_signed;
                cap_dvs <= divisor;
            end
        end
    end

    always_comb begin
        abs_rem = remainder[WIDTH-1] ? (~remainder + 1'b1) : remainder;
        abs_dvs = cap_dvs[WIDTH-1] ? (~cap_dvs + 1'b1) : cap_dvs;
    end

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6
    busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    // R5
    run_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !div_zero) |-> (run_len == LW'(WIDTH)));

    // R5
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && divisor != '0) |=> busy);

    // R7
    zero_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && divisor == '0) |=> (done && div_zero && !busy));

    // R9
    hold_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(quotient) && $stable(remainder)));

    // R2
    urem_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !div_zero && !cap_sgn) |-> (remainder < cap_dvs));

    // R4
    srem_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !div_zero && cap_sgn && cap_dvs != {1'b1, {(WIDTH-1){1'b0}}})
        |-> (abs_rem < abs_dvs));
endmodule

bind seq_divider divider_chk #(.WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .is_signed (is_signed),
    .dividend  (dividend),
    .divisor   (divisor),
    .busy      (busy),
    .done      (done),
    .quotient  (quotient),
    .remainder (remainder),
    .div_zero  (div_zero)
);

// File: tb/test_seq_divider.sv
`timescale 1ns/1ps
module test_seq_divider;
    localparam int W = 8;
    localparam int NV = 15;

    // {signed, dividend, divisor, quotient, remainder}
    localparam logic [32:0] VEC [NV] = '{
        {1'b0, 8'd147, 8'd11,  8'd13,  8'd4},    // R2
        {1'b0, 8'd255, 8'd1,   8'd255, 8'd0},    // R2
        {1'b0, 8'd200, 8'd201, 8'd0,   8'd200},  // R2
        {1'b0, 8'd255, 8'd16,  8'd15,  8'd15},   // R2
        {1'b0, 8'd100, 8'd10,  8'd10,  8'd0},    // R2
        {1'b0, 8'd128, 8'd3,   8'd42,  8'd2},    // R2
        {1'b1, 8'hF9,  8'h02,  8'hFD,  8'hFF},   // R3 R4 -7/2
        {1'b1, 8'h07,  8'hFE,  8'hFD,  8'h01},   // R3 R4 7/-2
        {1'b1, 8'hF9,  8'hFE,  8'h03,  8'hFF},   // R3 R4 -7/-2
        {1'b1, 8'h80,  8'hFF,  8'h80,  8'h00},   // R10
        {1'b1, 8'hFA,  8'h03,  8'hFE,  8'h00},   // R3 -6/3
        {1'b1, 8'h64,  8'h07,  8'h0E,  8'h02},   // R3 100/7
        {1'b1, 8'h80,  8'h7F,  8'hFF,  8'hFF},   // R4 -128/127
        {1'b1, 8'h7F,  8'h80,  8'h00,  8'h7F},   // R4 127/-128
        {1'b1, 8'hFF,  8'h05,  8'h00,  8'hFF}    // R4 -1/5
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         is_signed = 1'b0;
    logic [W-1:0] dividend = '0;
    logic [W-1:0] divisor = '0;
    logic         busy, done, div_zero;
    logic [W-1:0] quotient, remainder;

    int checks = 0;
    int errors = 0;
    int cycles;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    seq_divider #(.WIDTH(W)) i_seq_divider (
        .clk(clk), .rst_n(rst_n), .start(start), .is_signed(is_signed),
        .dividend(dividend), .divisor(divisor), .busy(busy), .done(done),
        .quotient(quotient), .remainder(remainder), .div_zero(div_zero)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // pulse start, then count negedges until done; returns that count
    task automatic run_op(input logic sg, input logic [W-1:0] dd, input logic [W-1:0] dv,
                          output int n);
        @(negedge clk);
        start = 1'b1; is_signed = sg; dividend = dd; divisor = dv;
        n = 0;
        do begin
            @(negedge clk);
            start = 1'b0;
            n++;
        end while (!done && n < 100);
    endtask

    initial begin
        #200000;
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 during reset
        chk(!busy && !done && !div_zero, "R1 flags in reset", {busy, done, div_zero}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(quotient == 0 && remainder == 0, "R1 results after reset",
            {quotient, remainder}, 0);
        chk(!busy && !done && !div_zero, "R1 flags after reset", {busy, done, div_zero}, 0);

        for (int i = 0; i < NV; i++) begin
            run_op(VEC[i][32], VEC[i][31:24], VEC[i][23:16], cycles);
            chk(cycles == W + 1, "R5 latency", cycles, W + 1);
            chk(quotient == VEC[i][15:8], VEC[i][32] ? "R3 quotient" : "R2 quotient",
                quotient, VEC[i][15:8]);
            chk(remainder == VEC[i][7:0], VEC[i][32] ? "R4 remainder" : "R2 remainder",
                remainder, VEC[i][7:0]);
            @(negedge clk);
            chk(!done, "R6 done single cycle", done, 0);
        end

        // R7 zero divisor
        run_op(1'b0, 8'h5A, 8'h00, cycles);
        chk(cycles == 1, "R7 immediate completion", cycles, 1);
        chk(div_zero && !busy, "R7 flag", {div_zero, busy}, 2);
        chk(quotient == 8'hFF && remainder == 8'h5A, "R7 results",
            {quotient, remainder}, 16'hFF5A);

        // R9 held while idle, inputs ignored
        @(negedge clk);
        dividend = 8'h33; divisor = 8'h07; is_signed = 1'b1;
        repeat (4) @(negedge clk);
        chk(div_zero && quotient == 8'hFF && remainder == 8'h5A, "R9 hold",
            {div_zero, quotient, remainder}, 17'h1FF5A);

        // R9 next accepted start clears the flag
        run_op(1'b0, 8'd50, 8'd7, cycles);
        chk(!div_zero, "R9 flag cleared", div_zero, 0);
        chk(quotient == 8'd7 && remainder == 8'd1, "R2 50/7", {quotient, remainder}, 16'h0701);

        // R8 start during busy ignored
        @(negedge clk);
        start = 1'b1; is_signed = 1'b0; dividend = 8'd147; divisor = 8'd11;
        @(negedge clk);
        start = 1'b0;
        repeat (2) @(negedge clk);
        start = 1'b1; dividend = 8'd10; divisor = 8'd3;
        @(negedge clk);
        start = 1'b0;
        cycles = 4;
        while (!done && cycles < 100) begin
            @(negedge clk);
            cycles++;
        end
        chk(cycles == W + 1, "R8 timing kept", cycles, W + 1);
        chk(quotient == 8'd13 && remainder == 8'd4, "R8 result kept",
            {quotient, remainder}, 16'h0D04);
        @(negedge clk);
        chk(!busy && !done, "R8 no second run", {busy, done}, 0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule